// File: doc/BRIEF.md
# Scalar-Vector Synchronization Responder

This block sits on the vector side of a scalar/vector processor pair and answers synchronization requests raised by the scalar issuer. There are two kinds of request. An instruction sync makes sure that exceptions from earlier vector work reach the scalar side. A memory sync makes sure that memory traffic from both sides has stopped and that vector writes have become visible. While a request is outstanding, the scalar side is held and issues nothing more.

A request is taken with a valid/ready handshake. At the moment of acceptance the block looks at the unreported-exception flag. If that flag is set, the request faults. Otherwise the request waits until the quiescence condition for its kind holds, and then it completes. Either outcome is a single-cycle pulse. A fault pulse carries a one-bit fault type. A completion carries a 32-bit data word whose value has no meaning and is driven as zero.

The controller is a four-state machine:
- `ST_IDLE` is ready for a request. Its exits are accept→`ST_FAULT` when an exception is pending, and accept→`ST_WAIT` otherwise.
- `ST_WAIT` holds until the quiescence condition holds, then moves quiet→`ST_DONE`.
- `ST_DONE` drives the completion pulse and always returns→`ST_IDLE`.
- `ST_FAULT` drives the fault pulse and always returns→`ST_IDLE`.

Top module: `svsync_responder`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. From that edge until after the response pulse, `req_ready` stays low, so a `req_valid` held high in that time is not taken.
- R2: If `exc_pending` is high on the accepting edge, `rsp_fault` pulses in the cycle right after that edge, and no completion is produced for that request.
- R3: Fault type encoding on `rsp_fault_type`: 0 means vector-disabled and 1 means memory-management. The unit counts as disabled when `vu_enable` is 0 or any bit of `err_flags` is 1. The type is 1 only when `mm_exc` is 1 and the unit is not disabled. When both a disable and `mm_exc` apply, the type is 0.
- R4: An instruction sync (`req_kind`=0) with no pending exception completes once `vu_idle` is 1 or the unit is disabled. `rsp_done` pulses one cycle after the edge in `ST_WAIT` at which this holds.
- R5: A memory sync (`req_kind`=1) with no pending exception completes only when `vu_mem_active`=0, `sc_mem_active`=0 and `wr_visible`=1. The value of `vu_idle` has no effect on it, whether it is high (not proof of visibility) or low (instructions need not finish).
- R6: `rsp_data` is all zeros on a completion, and it is also zero on a fault (no data delivered).
- R7: Each accepted request produces exactly one response pulse, one cycle long. `rsp_done` and `rsp_fault` are never high together.
- R8: The exception check happens only at acceptance. A rise of `exc_pending` during `ST_WAIT` does not turn the request into a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sync request present |
| req_kind | input | 1 | 0 = instruction sync, 1 = memory sync |
| req_ready | output | 1 | Block can take a request |
| exc_pending | input | 1 | An earlier vector instruction has an unreported exception |
| vu_enable | input | 1 | Vector unit enable state |
| err_flags | input | N_ERR | Error-class flags; any set bit disables the unit |
| mm_exc | input | 1 | Memory-management exception outstanding |
| vu_idle | input | 1 | Vector unit has no work in progress |
| vu_mem_active | input | 1 | Vector side memory operations in flight |
| sc_mem_active | input | 1 | Scalar side memory operations in flight |
| wr_visible | input | 1 | Vector writes are visible to the scalar side |
| rsp_done | output | 1 | Completion pulse |
| rsp_data | output | DATA_W | Completion data word (zero) |
| rsp_fault | output | 1 | Fault pulse |
| rsp_fault_type | output | 1 | 0 vector-disabled, 1 memory-management |

## Verification
The instruction sync is tried in three ways: with the unit already idle, with the unit busy and later going idle, and with the unit busy but disabled. This shows that idle and disabled are each enough on their own to complete it. The memory sync is run with the unit idle while writes are not yet visible, then with scalar traffic still active, and then with the unit busy but all memory quiet. These runs separate the memory condition from the busy indication. Fault runs combine pending exceptions with disable, error flags and memory-management flags to show the type priority. One run raises the exception flag only after acceptance to confirm that the check is made once, at acceptance. Another holds `req_valid` high through a wait to confirm that a single response comes back.

// File: rtl/svsync_pkg.sv
package svsync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } sync_state_t;

    typedef enum logic {
        KIND_INSTR = 1'b0,
        KIND_MEM   = 1'b1
    } sync_kind_t;

    typedef enum logic {
        FT_VDIS = 1'b0,
        FT_MMGT = 1'b1
    } fault_type_t;
endpackage

// File: rtl/svsync_quiesce.sv
module svsync_quiesce
    import svsync_pkg::*;
#(
    parameter int N_ERR = 4
) (
    input  sync_kind_t       kind,
    input  logic             vu_enable,
    input  logic [N_ERR-1:0] err_flags,
    input  logic             vu_idle,
    input  logic             vu_mem_active,
    input  logic             sc_mem_active,
    input  logic             wr_visible,
    output logic             disabled,
    output logic             quiet
);
    logic instr_quiet;
    logic mem_quiet;

    // Any error class, or a cleared enable, takes the unit out of service.
    assign disabled    = !vu_enable || (|err_flags);
    assign instr_quiet = vu_idle || disabled;
    // Busy state is deliberately absent: only traffic and visibility count.
    assign mem_quiet   = !vu_mem_active && !sc_mem_active && wr_visible;

    always_comb begin
        unique case (kind)
            KIND_INSTR: quiet = instr_quiet;
            KIND_MEM:   quiet = mem_quiet;
            default:    quiet = 1'b0;
        endcase
    end
endmodule

// File: rtl/svsync_fault_sel.sv
module svsync_fault_sel
    import svsync_pkg::*;
(
    input  logic        disabled,
    input  logic        mm_exc,
    output fault_type_t ftype
);
    // A disable outranks a memory-management exception.
    always_comb begin
        if (!disabled && mm_exc) ftype = FT_MMGT;
        else                     ftype = FT_VDIS;
    end
endmodule

// File: rtl/svsync_responder.sv
module svsync_responder
    import svsync_pkg::*;
#(
    parameter int N_ERR  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kind,
    output logic              req_ready,
    input  logic              exc_pending,
    input  logic              vu_enable,
    input  logic [N_ERR-1:0]  err_flags,
    input  logic              mm_exc,
    input  logic              vu_idle,
    input  logic              vu_mem_active,
    input  logic              sc_mem_active,
    input  logic              wr_visible,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_fault,
    output logic              rsp_fault_type
);
    localparam logic [DATA_W-1:0] DONT_CARE_WORD = '0;

    sync_state_t state_q, state_d;
    sync_kind_t  kind_q;
    fault_type_t ftype_q;
    fault_type_t ftype_now;
    logic        disabled_now;
    logic        quiet_now;
    logic        accept;

    assign accept = req_valid && (state_q == ST_IDLE);

    svsync_quiesce #(.N_ERR(N_ERR)) u_quiesce (
        .kind          (kind_q),
        .vu_enable     (vu_enable),
        .err_flags     (err_flags),
        .vu_idle       (vu_idle),
        .vu_mem_active (vu_mem_active),
        .sc_mem_active (sc_mem_active),
        .wr_visible    (wr_visible),
        .disabled      (disabled_now),
        .quiet         (quiet_now)
    );

    svsync_fault_sel u_fault_sel (
        .disabled (disabled_now),
        .mm_exc   (mm_exc),
        .ftype    (ftype_now)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = exc_pending ? ST_FAULT : ST_WAIT;
            ST_WAIT:  if (quiet_now) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_INSTR;
            ftype_q <= FT_VDIS;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= sync_kind_t'(req_kind);
                ftype_q <= ftype_now;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready      = 1'b0;
        rsp_done       = 1'b0;
        rsp_fault      = 1'b0;
        rsp_fault_type = 1'b0;
        rsp_data       = DONT_CARE_WORD;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_WAIT:  req_ready = 1'b0;
            ST_DONE:  rsp_done  = 1'b1;
            ST_FAULT: begin
                rsp_fault      = 1'b1;
                rsp_fault_type = ftype_q;
            end
            default:  req_ready = 1'b0;
        endcase
    end

    // R1: no second acceptance right after a take
    a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2: pending exception at acceptance faults next cycle
    a_r2_pending_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && exc_pending) |=> (rsp_fault && !rsp_done));

    // R3: disable outranks memory management
    a_r3_vdis_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && exc_pending && (!vu_enable || (|err_flags)))
        |=> (rsp_fault_type == 1'b0));

    // R3: memory-management type when unit stays enabled
    a_r3_mmgt_type: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && exc_pending && vu_enable && !(|err_flags) && mm_exc)
        |=> (rsp_fault_type == 1'b1));

    // R5: memory sync completion needs quiet memory and visible writes
    a_r5_mem_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && kind_q == KIND_MEM)
        |-> $past(!vu_mem_active && !sc_mem_active && wr_visible));

    // R7: pulses exclusive and single-cycle
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_fault));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/svsync_responder_bench.sv
`timescale 1ns/1ps
module svsync_responder_bench;
    localparam int   N_ERR  = 4;
    localparam int   DATA_W = 32;
    localparam real  HALF   = 2.5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_kind = 1'b0;
    logic              req_ready;
    logic              exc_pending = 1'b0;
    logic              vu_enable = 1'b1;
    logic [N_ERR-1:0]  err_flags = '0;
    logic              mm_exc = 1'b0;
    logic              vu_idle = 1'b1;
    logic              vu_mem_active = 1'b0;
    logic              sc_mem_active = 1'b0;
    logic              wr_visible = 1'b1;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_fault;
    logic              rsp_fault_type;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit    is_fault;
        bit    ftype;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #(HALF) clk = ~clk;

    svsync_responder #(.N_ERR(N_ERR), .DATA_W(DATA_W)) u_svsync_responder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_ready(req_ready),
        .exc_pending(exc_pending), .vu_enable(vu_enable), .err_flags(err_flags),
        .mm_exc(mm_exc), .vu_idle(vu_idle), .vu_mem_active(vu_mem_active),
        .sc_mem_active(sc_mem_active), .wr_visible(wr_visible),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
        .rsp_fault_type(rsp_fault_type)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every response pulse
    always @(negedge clk) begin
        if (rst_n && (rsp_done || rsp_fault)) begin
            check(!(rsp_done && rsp_fault), "R7", "done and fault together",
                  {30'd0, rsp_done, rsp_fault}, 32'd1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected response",
                      {30'd0, rsp_done, rsp_fault}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_fault == e.is_fault, e.req, "response kind (fault)",
                      {31'd0, rsp_fault}, {31'd0, e.is_fault});
                if (e.is_fault)
                    check(rsp_fault_type == e.ftype, "R3", "fault type",
                          {31'd0, rsp_fault_type}, {31'd0, e.ftype});
                check(rsp_data == '0, "R6", "data word", rsp_data, 32'd0);
            end
        end
    end

    task automatic push_exp(input bit is_fault, input bit ftype, input string req);
        exp_t e;
        e.is_fault = is_fault;
        e.ftype    = ftype;
        e.req      = req;
        exp_q.push_back(e);
    endtask

    // Drive one request; returns at the negedge after the accepting edge
    task automatic issue(input bit kind, input bit keep_valid);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        @(posedge clk);
        @(negedge clk);
        if (!keep_valid) req_valid = 1'b0;
    endtask

    task automatic hold_silent(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            #1;
            check(!rsp_done && !rsp_fault, req, "response while waiting",
                  {30'd0, rsp_done, rsp_fault}, 32'd0);
            check(!req_ready, "R1", "ready while outstanding", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 20; i++) begin
            #1;
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, req, "response missing", exp_q.size(), 32'd0);
        exp_q.delete();
    endtask

    task automatic restore_defaults();
        exc_pending = 1'b0; vu_enable = 1'b1; err_flags = '0; mm_exc = 1'b0;
        vu_idle = 1'b1; vu_mem_active = 1'b0; sc_mem_active = 1'b0; wr_visible = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R1", "reset ready", {31'd0, req_ready}, 32'd1);
        check(!rsp_done && !rsp_fault, "R7", "reset pulses", {30'd0, rsp_done, rsp_fault}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: instruction sync, already idle
        push_exp(1'b0, 1'b0, "R4");
        issue(1'b0, 1'b0);
        drain("R4");

        // R4/R1/R7: busy, valid held high through the wait
        vu_idle = 1'b0;
        push_exp(1'b0, 1'b0, "R4");
        issue(1'b0, 1'b1);
        hold_silent(5, "R4");
        vu_idle = 1'b1;
        drain("R4");
        req_valid = 1'b0;
        @(negedge clk);
        hold_silent_idle: for (int i = 0; i < 4; i++) begin
            #1;
            check(!rsp_done && !rsp_fault, "R7", "extra response",
                  {30'd0, rsp_done, rsp_fault}, 32'd0);
            check(req_ready, "R1", "ready back in idle", {31'd0, req_ready}, 32'd1);
            @(negedge clk);
        end

        // R4: busy but disabled completes
        vu_idle = 1'b0; vu_enable = 1'b0;
        push_exp(1'b0, 1'b0, "R4");
        issue(1'b0, 1'b0);
        drain("R4");
        restore_defaults();

        // R2/R3: pending with disable by error flag and mm exception
        exc_pending = 1'b1; err_flags = 4'b0100; mm_exc = 1'b1;
        push_exp(1'b1, 1'b0, "R2");
        issue(1'b0, 1'b0);
        drain("R2");
        restore_defaults();

        // R3: pending, enabled, mm exception -> type 1
        exc_pending = 1'b1; mm_exc = 1'b1;
        push_exp(1'b1, 1'b1, "R3");
        issue(1'b0, 1'b0);
        drain("R3");
        restore_defaults();

        // R3: pending, enabled, no mm -> type 0
        exc_pending = 1'b1;
        push_exp(1'b1, 1'b0, "R3");
        issue(1'b0, 1'b0);
        drain("R3");
        restore_defaults();

        // R5: memory sync, idle but writes not visible, then scalar active
        wr_visible = 1'b0; vu_enable = 1'b0;
        push_exp(1'b0, 1'b0, "R5");
        issue(1'b1, 1'b0);
        hold_silent(4, "R5");
        wr_visible = 1'b1; sc_mem_active = 1'b1;
        @(negedge clk);
        hold_silent(3, "R5");
        sc_mem_active = 1'b0; vu_mem_active = 1'b1;
        @(negedge clk);
        hold_silent(3, "R5");
        vu_mem_active = 1'b0;
        drain("R5");
        restore_defaults();

        // R5: busy unit with quiet memory completes
        vu_idle = 1'b0;
        push_exp(1'b0, 1'b0, "R5");
        issue(1'b1, 1'b0);
        drain("R5");
        restore_defaults();

        // R8: exception raised after acceptance is ignored
        vu_idle = 1'b0;
        push_exp(1'b0, 1'b0, "R8");
        issue(1'b0, 1'b0);
        exc_pending = 1'b1; mm_exc = 1'b1;
        hold_silent(3, "R8");
        vu_idle = 1'b1;
        drain("R8");
        restore_defaults();

        // R2: memory sync with pending exception faults
        exc_pending = 1'b1;
        push_exp(1'b1, 1'b0, "R2");
        issue(1'b1, 1'b0);
        drain("R2");
        restore_defaults();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule